// File: doc/BRIEF.md
# Probabilistic Counter Rescale Engine

This block holds a bank of per-flow counters. Each counter is not a count but a small index into a shared table of estimate values. The values grow non-uniformly, so a few bits can cover a very large range. Two tables are kept, and one of them is active. When a counter is written with an index at or above a threshold, the engine starts an up-scale sweep. It moves every counter onto the coarser scale that software has already loaded into the inactive table.

For each counter the engine reads the old estimate `v` from the active table. It then searches the new table for the largest index `j` whose value does not exceed `v`. If `v` falls strictly between new entries `j` and `j+1`, the counter moves to `j+1` with probability `(v - new[j]) / (new[j+1] - new[j])` and to `j` otherwise, so the expected estimate is preserved. The fraction is formed by a sequential divider and compared against a 16-bit pseudo-random sample. When the last counter has been rewritten, the active table select flips and a one-cycle completion pulse follows.

While a sweep runs, counter writes are held off through a ready signal. A read port returns any counter's index and its current estimate.

Top module: `pc_rescale`

## Requirements
- R1: After reset, busy and done are 0, cnt_ready is 1, act_bank is 0 and every counter index reads 0.
- R2: A counter write whose index is below up_thresh leaves busy at 0. A write with index >= up_thresh, accepted while armed, raises busy on the next clock edge and drops cnt_ready.
- R3: A counter write presented while busy is 1 is discarded; the counter holds the value that the sweep gives it.
- R4: An old estimate equal to a new table entry maps to that entry's index, with no random step.
- R5: An old estimate strictly between new entries j and j+1 maps to j or j+1 only.
- R6: Over many samples, the share of counters that round up matches (v - new[j]) / (new[j+1] - new[j]) within statistical tolerance.
- R7: An old estimate at or above the last new entry maps to the last index, L-1.
- R8: act_bank changes only during a sweep, after the last counter is rewritten. done is high for exactly one cycle, the cycle after the change. rd_est then reads from the newly active table.
- R9: The engine re-arms when done fires, so a later write that reaches up_thresh starts a new sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table write strobe (ignored while busy) |
| tbl_bank | input | 1 | Table bank being written |
| tbl_addr | input | IDXW | Table entry index |
| tbl_wdata | input | VALW | Estimate value to store |
| cnt_we | input | 1 | Counter write strobe |
| cnt_addr | input | $clog2(NCNT) | Counter number |
| cnt_wdata | input | IDXW | New counter index |
| cnt_ready | output | 1 | Counter writes are accepted |
| up_thresh | input | IDXW | Index that triggers an up-scale |
| rd_addr | input | $clog2(NCNT) | Counter to read |
| rd_idx | output | IDXW | Index held by that counter |
| rd_est | output | VALW | Active-table estimate for that index |
| busy | output | 1 | Sweep in progress |
| act_bank | output | 1 | Active table bank |
| done | output | 1 | One-cycle pulse after the bank swap |

## Verification
The bench uses the defaults: 16 counters, 4-bit indices (16-entry tables) and 16-bit estimates. With these values a full sweep takes a few hundred cycles, which leaves room for 32 back-to-back sweeps and about 450 rounding decisions on the 54-between-24-and-93 case, enough to bound the round-up rate near 0.43. The 16-entry tables let a single sweep cover exact hits, bracketed values at every search depth, and an old value above the whole new table.

// File: rtl/pc_rescale.sv
`timescale 1ns/1ps
module pc_rescale #(
  parameter int NCNT = 16,
  parameter int IDXW = 4,
  parameter int VALW = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tbl_we,
  input  logic                    tbl_bank,
  input  logic [IDXW-1:0]         tbl_addr,
  input  logic [VALW-1:0]         tbl_wdata,
  input  logic                    cnt_we,
  input  logic [$clog2(NCNT)-1:0] cnt_addr,
  input  logic [IDXW-1:0]         cnt_wdata,
  output logic                    cnt_ready,
  input  logic [IDXW-1:0]         up_thresh,
  input  logic [$clog2(NCNT)-1:0] rd_addr,
  output logic [IDXW-1:0]         rd_idx,
  output logic [VALW-1:0]         rd_est,
  output logic                    busy,
  output logic                    act_bank,
  output logic                    done
);
  localparam int L  = 1 << IDXW;
  localparam int CW = $clog2(NCNT);
  localparam int BW = $clog2(IDXW + 1);
  localparam int PW = 16;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_SRCH, S_EVAL, S_DIV, S_DEC, S_SWAP, S_DONE} st_t;

  st_t             st;
  logic [VALW-1:0] tbl [2][L];
  logic [IDXW-1:0] cmem [NCNT];
  logic            bank, armed;
  logic [CW-1:0]   ci;
  logic [VALW-1:0] v, den, rem;
  logic [IDXW-1:0] j;
  logic [BW-1:0]   b;
  logic [PW-1:0]   quo, lfsr;
  logic [3:0]      dcnt;

  wire             nb   = ~bank;
  wire [IDXW-1:0]  cand = j | (IDXW'(1) << b);
  wire [VALW-1:0]  lo   = tbl[nb][j];
  wire [VALW-1:0]  hi   = tbl[nb][IDXW'(j + IDXW'(1))];
  wire [VALW:0]    rem2 = {rem, 1'b0};
  wire             ge   = rem2 >= {1'b0, den};
  wire             last = ci == CW'(NCNT - 1);
  wire             fb   = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];

  assign busy      = st != S_IDLE;
  assign cnt_ready = !busy;
  assign act_bank  = bank;
  assign done      = st == S_DONE;
  assign rd_idx    = cmem[rd_addr];
  assign rd_est    = tbl[bank][rd_idx];

  always_ff @(posedge clk)
    if (tbl_we && st == S_IDLE) tbl[tbl_bank][tbl_addr] <= tbl_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; bank <= 1'b0; armed <= 1'b1; ci <= '0;
      v <= '0; den <= '0; rem <= '0; j <= '0; b <= '0;
      quo <= '0; dcnt <= '0; lfsr <= 16'hACE1;
      for (int k = 0; k < NCNT; k++) cmem[k] <= '0;
    end else begin
      lfsr <= {lfsr[14:0], fb};
      case (st)
        S_IDLE: if (cnt_we) begin
          cmem[cnt_addr] <= cnt_wdata;
          if (armed && cnt_wdata >= up_thresh) begin
            armed <= 1'b0; ci <= '0; st <= S_LOAD;
          end
        end
        S_LOAD: begin
          v <= tbl[bank][cmem[ci]]; j <= '0; b <= BW'(IDXW - 1); st <= S_SRCH;
        end
        S_SRCH: begin
          if (tbl[nb][cand] <= v) j <= cand;
          if (b == '0) st <= S_EVAL;
          else b <= b - BW'(1);
        end
        S_EVAL: if (j == IDXW'(L - 1) || lo == v) begin
          cmem[ci] <= j;
          if (last) st <= S_SWAP;
          else begin ci <= ci + CW'(1); st <= S_LOAD; end
        end else begin
          rem <= v - lo; den <= hi - lo; quo <= '0; dcnt <= '0; st <= S_DIV;
        end
        S_DIV: begin
          rem  <= VALW'(ge ? rem2 - {1'b0, den} : rem2);
          quo  <= {quo[PW-2:0], ge};
          dcnt <= dcnt + 4'd1;
          if (dcnt == 4'(PW - 1)) st <= S_DEC;
        end
        S_DEC: begin
          cmem[ci] <= j + IDXW'(lfsr < quo);
          if (last) st <= S_SWAP;
          else begin ci <= ci + CW'(1); st <= S_LOAD; end
        end
        S_SWAP: begin bank <= nb; st <= S_DONE; end
        S_DONE: begin armed <= 1'b1; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pc_rescale_chk.sv
`timescale 1ns/1ps
module pc_rescale_chk #(parameter int IDXW = 4) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            act_bank,
  input logic            armed,
  input logic            cnt_we,
  input logic            cnt_ready,
  input logic [IDXW-1:0] cnt_wdata,
  input logic [IDXW-1:0] up_thresh
);
  a_r2_start_sweep: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_we && cnt_ready && armed && cnt_wdata >= up_thresh) |=> busy);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_after_swap: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> act_bank != $past(act_bank));
  a_r8_swap_in_sweep: assert property (@(posedge clk) disable iff (!rst_n)
    (act_bank != $past(act_bank)) |-> $past(busy));
  a_r9_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> armed);
endmodule

bind pc_rescale pc_rescale_chk #(.IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .act_bank(act_bank),
  .armed(armed), .cnt_we(cnt_we), .cnt_ready(cnt_ready),
  .cnt_wdata(cnt_wdata), .up_thresh(up_thresh)
);

// File: tb/pc_rescale_test.sv
`timescale 1ns/1ps
module pc_rescale_test;
  localparam int NCNT = 16, IDXW = 4, VALW = 16;

  logic clk = 0, rst_n = 0;
  logic tbl_we = 0, tbl_bank = 0, cnt_we = 0;
  logic [IDXW-1:0] tbl_addr = '0, cnt_wdata = '0, up_thresh = '0, rd_idx;
  logic [VALW-1:0] tbl_wdata = '0, rd_est;
  logic [3:0] cnt_addr = '0, rd_addr = '0;
  logic cnt_ready, busy, act_bank, done;
  int checks = 0, errors = 0, ups = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pc_rescale #(.NCNT(NCNT), .IDXW(IDXW), .VALW(VALW)) uut (.*);

  // {old index, lowest allowed new index, highest allowed new index}
  localparam logic [11:0] VEC [16] = '{
    {4'd0,4'd0,4'd0}, {4'd1,4'd1,4'd1}, {4'd2,4'd1,4'd2}, {4'd3,4'd1,4'd2},
    {4'd4,4'd2,4'd2}, {4'd5,4'd2,4'd3}, {4'd6,4'd2,4'd3}, {4'd7,4'd2,4'd3},
    {4'd8,4'd2,4'd3}, {4'd9,4'd3,4'd3}, {4'd10,4'd3,4'd4}, {4'd11,4'd3,4'd4},
    {4'd12,4'd3,4'd4}, {4'd13,4'd3,4'd4}, {4'd14,4'd3,4'd4}, {4'd15,4'd3,4'd4}};

  function automatic int old_b(int k);
    case (k) 0: return 0; 1: return 54; 2: return 70; 3: return 93; 4: return 100;
      default: return 60000 + k; endcase
  endfunction
  function automatic int new_b(int k);
    case (k) 0: return 0; 1: return 24; 2: return 93; default: return 3500 * k; endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin errors++; $display("FAIL %s: got %0d expected %0d", req, act, exp); end
  endtask
  task automatic chk_in(string req, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++; $display("FAIL %s: got %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask
  task automatic wr_tbl(bit bk, int a, int d);
    @(negedge clk); tbl_we = 1; tbl_bank = bk; tbl_addr = IDXW'(a); tbl_wdata = VALW'(d);
    @(negedge clk); tbl_we = 0;
  endtask
  task automatic wr_cnt(int a, int d);
    @(negedge clk); cnt_we = 1; cnt_addr = 4'(a); cnt_wdata = IDXW'(d);
    @(negedge clk); cnt_we = 0;
  endtask
  task automatic wait_done(bit exp_bank);
    while (!done) @(negedge clk);
    chk("R8 bank after swap", int'(act_bank), int'(exp_bank));
    @(negedge clk);
    chk("R8 done one cycle", int'(done), 0);
  endtask
  task automatic rd(int a);
    rd_addr = 4'(a); #0.5;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 ready", int'(cnt_ready), 1);
    chk("R1 bank", int'(act_bank), 0);
    rd(7); chk("R1 counter", int'(rd_idx), 0);

    for (int k = 0; k < 16; k++) begin wr_tbl(0, k, 10 * k); wr_tbl(1, k, 10 * k * k); end
    up_thresh = 4'd15;
    for (int k = 0; k < 15; k++) wr_cnt(k, int'(VEC[k][11:8]));
    chk("R2 below threshold no sweep", int'(busy), 0);
    wr_cnt(15, 15);
    chk("R2 busy after trigger", int'(busy), 1);
    chk("R2 ready dropped", int'(cnt_ready), 0);
    wr_cnt(0, 7);
    wait_done(1);
    for (int k = 0; k < 16; k++) begin
      rd(k);
      if (VEC[k][7:4] == VEC[k][3:0])
        chk("R4 exact match", int'(rd_idx), int'(VEC[k][7:4]));
      else
        chk_in("R5 bracket", int'(rd_idx), int'(VEC[k][7:4]), int'(VEC[k][3:0]));
      chk("R8 estimate from new bank", int'(rd_est), 10 * int'(rd_idx) * int'(rd_idx));
    end
    rd(0); chk("R3 write during sweep dropped", int'(rd_idx), 0);

    for (int r = 0; r < 32; r++) begin
      for (int k = 0; k < 16; k++) begin
        wr_tbl(act_bank, k, old_b(k)); wr_tbl(!act_bank, k, new_b(k));
      end
      up_thresh = 4'd15;
      wr_cnt(0, 5); wr_cnt(1, 3);
      for (int k = 2; k < 16; k++) wr_cnt(k, 1);
      up_thresh = 4'd1;
      wr_cnt(15, 1);
      chk("R9 re-armed sweep starts", int'(busy), 1);
      if (r == 0) wr_cnt(1, 9);
      wait_done(r[0] ? 1'b1 : 1'b0);
      rd(0); chk("R7 above top maps to last", int'(rd_idx), 15);
      rd(1); chk(r == 0 ? "R3 write during sweep dropped" : "R4 exact match", int'(rd_idx), 2);
      for (int k = 2; k < 16; k++) begin
        rd(k); chk_in("R5 bracket", int'(rd_idx), 1, 2);
        if (rd_idx == 2) ups++;
      end
    end
    chk_in("R6 round-up share of 448", ups, 160, 230);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule